// File: doc/BRIEF.md
# Incremental Encoder Position and Speed Unit

This block turns the two phase signals and the index pulse of an incremental shaft encoder into a position count and two speed measures. Every change of either phase moves the count by one, so one encoder line gives four counts. The sign of the step follows the order in which the phases change. The count runs between zero and a programmable ceiling and wraps at both ends.

Two speed measures serve different shaft speeds. At low speed, a gap timer counts the clock cycles between consecutive valid phase edges and holds the last gap. At high speed, a free-running unit timer takes a snapshot of the position at a fixed interval, and software derives speed from the difference between two snapshots. A second gap timer acts as a stall watchdog. A detector flags any cycle in which both phases change together. A rising index edge captures the position.

All events land in sticky flags that are cleared by writing ones to `clr_i`, and any set flag raises the interrupt line. The phase and index inputs are expected to be already synchronised to `clk`.

Top module: `qenc_pos_speed`

## Requirements
- R1: After reset, `pos_o`, `unit_pos_o`, `cap_period_o`, `idx_pos_o`, `flags_o` and `irq_o` are zero, and `dir_o` is 1.
- R2: The phase state is taken as {A,B}. Each single-phase change in the forward order 00→10→11→01→00 adds one to `pos_o` and sets `dir_o` to 1. Each change in the reverse order subtracts one and sets `dir_o` to 0. `pos_o` shows the result right after the clock edge that first samples the new phase state.
- R3: Counting up from a value at or above `pos_max_i` gives 0. Counting down from 0 gives `pos_max_i`.
- R4: When A and B both change between two samples, flag bit 1 (phase error) is set and `pos_o` and `dir_o` keep their values.
- R5: On every valid phase edge, `cap_period_o` takes the number of clock cycles since the previous valid edge.
- R6: The gap count stops at all ones. While it is stopped, flag bit 3 (capture overflow) is set, and the next valid edge loads all ones into `cap_period_o`.
- R7: With `wdog_period_i` = P, flag bit 2 (stall) is set on the (P+1)th clock edge after a valid phase edge when no valid edge has arrived in between. Phase errors do not restart this count.
- R8: The unit timer expires once every `unit_period_i`+1 clock cycles. On expiry it sets flag bit 0 and loads `unit_pos_o` with the value `pos_o` held in that cycle.
- R9: Flags are sticky. A 1 in bit n of `clr_i` clears flag n at the next edge and leaves the other flags alone. A new event in the same cycle keeps the flag set.
- R10: A rising edge on the index input loads `idx_pos_o` with the current position and sets flag bit 4.
- R11: `irq_o` is high exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Phase A, synchronised |
| enc_b | input | 1 | Phase B, synchronised |
| enc_i | input | 1 | Index, synchronised |
| pos_max_i | input | POS_W | Position ceiling |
| unit_period_i | input | UNIT_W | Unit timer period minus one |
| wdog_period_i | input | WD_W | Stall watchdog limit |
| clr_i | input | 5 | Write-one-to-clear for the flags |
| pos_o | output | POS_W | Position count |
| dir_o | output | 1 | Direction of the last valid step (1 = up) |
| unit_pos_o | output | POS_W | Position captured at unit timer expiry |
| cap_period_o | output | CAP_W | Cycles between the last two valid edges |
| idx_pos_o | output | POS_W | Position captured at index rise |
| flags_o | output | 5 | Sticky flags: 0 unit, 1 phase error, 2 stall, 3 capture overflow, 4 index |
| irq_o | output | 1 | OR of all flags |

## Verification
The properties assume the phase inputs sit at 00 while reset is applied. The edge detector's history register resets to that state, so any other level would look like a step in the first cycle. The bench therefore holds A, B and index low through reset and changes them only at falling clock edges, one phase at a time, except where it provokes a phase error on purpose. The watchdog property also assumes that the limit is not zero when a valid edge arrives. The bench keeps every limit non-zero and changes a limit only while the counters are idle or just after they restart.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  localparam int FLG_N     = 5;
  localparam int FLG_UNIT  = 0;
  localparam int FLG_PHERR = 1;
  localparam int FLG_STALL = 2;
  localparam int FLG_COVF  = 3;
  localparam int FLG_INDEX = 4;

  typedef struct packed {
    logic vld;
    logic up;
    logic err;
  } qstep_t;

  // forward rotation of the {A,B} state: 00 -> 10 -> 11 -> 01 -> 00
  function automatic logic [1:0] fwd_of(input logic [1:0] s);
    case (s)
      2'b00:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic qstep_t qdec_step(input logic [1:0] prev, input logic [1:0] cur);
    qstep_t s;
    s = '0;
    if (prev != cur) begin
      if ((prev ^ cur) == 2'b11) begin
        s.err = 1'b1;
      end else begin
        s.vld = 1'b1;
        s.up  = (fwd_of(prev) == cur);
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enc_a,
  input  logic enc_b,
  input  logic enc_i,
  output logic step_vld_o,
  output logic step_up_o,
  output logic phase_err_o,
  output logic idx_rise_o
);

  logic [1:0] ab_q;
  logic       i_q;
  qstep_t     st;

  always_comb st = qdec_step(ab_q, {enc_a, enc_b});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q <= 2'b00;
      i_q  <= 1'b0;
    end else begin
      ab_q <= {enc_a, enc_b};
      i_q  <= enc_i;
    end
  end

  assign step_vld_o  = st.vld;
  assign step_up_o   = st.up;
  assign phase_err_o = st.err;
  assign idx_rise_o  = enc_i & ~i_q;

endmodule

// File: rtl/qenc_poscnt.sv
module qenc_poscnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_vld,
  input  logic         step_up,
  input  logic [W-1:0] pos_max,
  output logic [W-1:0] pos_o,
  output logic         dir_o
);

  function automatic logic [W-1:0] wrap_next(input logic [W-1:0] cur,
                                             input logic [W-1:0] top,
                                             input logic         up);
    if (up) return (cur >= top) ? '0 : cur + 1'b1;
    else    return (cur == '0)  ? top : cur - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_o <= '0;
      dir_o <= 1'b1;
    end else if (step_vld) begin
      pos_o <= wrap_next(pos_o, pos_max, step_up);
      dir_o <= step_up;
    end
  end

endmodule

// File: rtl/qenc_unittmr.sv
module qenc_unittmr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period,
  output logic         tick_o
);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/qenc_gaptmr.sv
module qenc_gaptmr #(
  parameter int          W           = 16,
  parameter int unsigned RESTART_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt_o,
  output logic         at_lim_o
);

  localparam logic [W-1:0] RST_V = W'(RESTART_VAL);

  assign at_lim_o = (cnt_o >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_o <= '0;
    else if (restart)   cnt_o <= RST_V;
    else if (!at_lim_o) cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/qenc_pos_speed.sv
module qenc_pos_speed
  import qenc_pkg::*;
#(
  parameter int POS_W  = 32,
  parameter int UNIT_W = 32,
  parameter int CAP_W  = 16,
  parameter int WD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_i,
  input  logic [POS_W-1:0]  pos_max_i,
  input  logic [UNIT_W-1:0] unit_period_i,
  input  logic [WD_W-1:0]   wdog_period_i,
  input  logic [FLG_N-1:0]  clr_i,
  output logic [POS_W-1:0]  pos_o,
  output logic              dir_o,
  output logic [POS_W-1:0]  unit_pos_o,
  output logic [CAP_W-1:0]  cap_period_o,
  output logic [POS_W-1:0]  idx_pos_o,
  output logic [FLG_N-1:0]  flags_o,
  output logic              irq_o
);

  localparam logic [CAP_W-1:0] CAP_TOP = '1;

  // named internal events
  logic             step_vld;
  logic             step_up;
  logic             phase_err;
  logic             idx_rise;
  logic             ut_tick;
  logic [CAP_W-1:0] cap_cnt;
  logic             cap_at_top;
  logic             cap_sat_evt;
  logic [WD_W-1:0]  wd_cnt;
  logic             wd_at_lim;
  logic             wd_stall_evt;
  logic [FLG_N-1:0] flg_set;

  qenc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_i(enc_i),
    .step_vld_o(step_vld), .step_up_o(step_up),
    .phase_err_o(phase_err), .idx_rise_o(idx_rise)
  );

  qenc_poscnt #(.W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .step_vld(step_vld), .step_up(step_up),
    .pos_max(pos_max_i), .pos_o(pos_o), .dir_o(dir_o)
  );

  qenc_unittmr #(.W(UNIT_W)) u_unit (
    .clk(clk), .rst_n(rst_n), .period(unit_period_i), .tick_o(ut_tick)
  );

  // edge gap timer: restarts at one so the latched value is the gap length
  qenc_gaptmr #(.W(CAP_W), .RESTART_VAL(1)) u_cap (
    .clk(clk), .rst_n(rst_n), .restart(step_vld), .limit(CAP_TOP),
    .cnt_o(cap_cnt), .at_lim_o(cap_at_top)
  );

  // stall watchdog: restarts at zero and holds at the limit
  qenc_gaptmr #(.W(WD_W), .RESTART_VAL(0)) u_wd (
    .clk(clk), .rst_n(rst_n), .restart(step_vld), .limit(wdog_period_i),
    .cnt_o(wd_cnt), .at_lim_o(wd_at_lim)
  );

  assign cap_sat_evt  = cap_at_top & ~step_vld;
  assign wd_stall_evt = wd_at_lim  & ~step_vld;

  always_comb begin
    flg_set            = '0;
    flg_set[FLG_UNIT]  = ut_tick;
    flg_set[FLG_PHERR] = phase_err;
    flg_set[FLG_STALL] = wd_stall_evt;
    flg_set[FLG_COVF]  = cap_sat_evt;
    flg_set[FLG_INDEX] = idx_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_pos_o   <= '0;
      cap_period_o <= '0;
      idx_pos_o    <= '0;
      flags_o      <= '0;
    end else begin
      if (ut_tick)  unit_pos_o   <= pos_o;
      if (step_vld) cap_period_o <= cap_cnt;
      if (idx_rise) idx_pos_o    <= pos_o;
      flags_o <= flg_set | (flags_o & ~clr_i);
    end
  end

  assign irq_o = |flags_o;

endmodule

// File: rtl/qenc_pos_speed_chk.sv
module qenc_pos_speed_chk #(
  parameter int POS_W = 32,
  parameter int WD_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_vld,
  input logic             step_up,
  input logic             phase_err,
  input logic             ut_tick,
  input logic             cap_sat_evt,
  input logic             wd_stall_evt,
  input logic [POS_W-1:0] pos_o,
  input logic             dir_o,
  input logic [POS_W-1:0] pos_max_i,
  input logic [WD_W-1:0]  wdog_period_i,
  input logic [POS_W-1:0] unit_pos_o,
  input logic [4:0]       flags_o,
  input logic [4:0]       clr_i
);

  // R2
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_vld |=> $stable(pos_o));

  // R3
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld && step_up && (pos_o >= pos_max_i) |=> pos_o == '0);

  // R3
  wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld && !step_up && (pos_o == '0) |=> pos_o == $past(pos_max_i));

  // R4
  phase_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err |=> flags_o[1] && $stable(pos_o) && $stable(dir_o));

  // R6
  cap_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_sat_evt |=> flags_o[3]);

  // R7
  wd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld && (wdog_period_i != '0) |=> !wd_stall_evt || (wdog_period_i == '0));

  // R8
  unit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ut_tick |=> (unit_pos_o == $past(pos_o)) && flags_o[0]);

  for (genvar g = 0; g < 5; g++) begin : g_sticky
    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[g] && !clr_i[g] |=> flags_o[g]);
  end

endmodule

bind qenc_pos_speed qenc_pos_speed_chk #(.POS_W(POS_W), .WD_W(WD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_vld(step_vld), .step_up(step_up),
  .phase_err(phase_err), .ut_tick(ut_tick), .cap_sat_evt(cap_sat_evt),
  .wd_stall_evt(wd_stall_evt), .pos_o(pos_o), .dir_o(dir_o), .pos_max_i(pos_max_i),
  .wdog_period_i(wdog_period_i), .unit_pos_o(unit_pos_o), .flags_o(flags_o),
  .clr_i(clr_i)
);

// File: tb/qenc_pos_speed_tb.sv
module qenc_pos_speed_tb;

  localparam int POS_W  = 32;
  localparam int UNIT_W = 16;
  localparam int CAP_W  = 8;
  localparam int WD_W   = 8;

  localparam int S_POS = 0, S_DIR = 1, S_FLG = 2, S_UPOS = 3, S_CAP = 4,
                 S_IPOS = 5, S_IRQ = 6, S_FBIT = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              enc_a, enc_b, enc_i;
  logic [POS_W-1:0]  pos_max;
  logic [UNIT_W-1:0] unit_p;
  logic [WD_W-1:0]   wdog;
  logic [4:0]        clr;
  logic [POS_W-1:0]  pos_o, unit_pos_o, idx_pos_o;
  logic              dir_o, irq_o;
  logic [CAP_W-1:0]  cap_period_o;
  logic [4:0]        flags_o;

  always #5 clk = ~clk;

  qenc_pos_speed #(.POS_W(POS_W), .UNIT_W(UNIT_W), .CAP_W(CAP_W), .WD_W(WD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_i(enc_i),
    .pos_max_i(pos_max), .unit_period_i(unit_p), .wdog_period_i(wdog), .clr_i(clr),
    .pos_o(pos_o), .dir_o(dir_o), .unit_pos_o(unit_pos_o), .cap_period_o(cap_period_o),
    .idx_pos_o(idx_pos_o), .flags_o(flags_o), .irq_o(irq_o)
  );

  typedef struct {
    int          req;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t sbq[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // bench-side model
  logic [1:0]  seq [4] = '{2'b00, 2'b10, 2'b11, 2'b01};
  int          ph = 0;
  logic [31:0] pos_m = 0;
  logic [31:0] max_m = 0;
  logic        dir_m = 1'b1;

  task automatic check(input int req, input int sel, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d sel=%0d actual=%0h expected=%0h", req, sel, act, exp);
    end
  endtask

  function automatic logic [31:0] probe(input int sel);
    case (sel)
      S_POS:   return pos_o;
      S_DIR:   return {31'd0, dir_o};
      S_FLG:   return {27'd0, flags_o};
      S_UPOS:  return unit_pos_o;
      S_CAP:   return {24'd0, cap_period_o};
      S_IPOS:  return idx_pos_o;
      S_IRQ:   return {31'd0, irq_o};
      default: return {31'd0, flags_o[sel-S_FBIT]};
    endcase
  endfunction

  task automatic expect_(input int req, input int sel, input logic [31:0] v);
    sbq.push_back('{req, sel, v});
  endtask

  // monitor: compares queued expectations a little after each falling edge
  always @(negedge clk) begin
    #2;
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(it.req, it.sel, probe(it.sel), it.exp);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mv(input bit up);
    ph = up ? (ph + 1) % 4 : (ph + 3) % 4;
    {enc_a, enc_b} = seq[ph];
    if (up) pos_m = (pos_m >= max_m) ? 0 : pos_m + 1;
    else    pos_m = (pos_m == 0) ? max_m : pos_m - 1;
    dir_m = up;
    @(negedge clk);
  endtask

  task automatic clear(input logic [4:0] m);
    clr = m;
    @(negedge clk);
    clr = '0;
  endtask

  task automatic wait_unit(output int c);
    c = 0;
    while (!flags_o[0] && c < 1000) begin
      @(negedge clk);
      c++;
    end
  endtask

  initial begin
    int c;
    rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0; enc_i = 1'b0; clr = '0;
    pos_max = 1000; max_m = 1000; unit_p = '1; wdog = 200;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_(1, S_POS, 0); expect_(1, S_DIR, 1); expect_(1, S_FLG, 0);
    expect_(1, S_IRQ, 0); expect_(1, S_UPOS, 0); expect_(1, S_CAP, 0);
    expect_(1, S_IPOS, 0);
    @(negedge clk);

    // R2 forward and reverse counting
    for (int k = 0; k < 4; k++) begin
      mv(1); expect_(2, S_POS, pos_m); expect_(2, S_DIR, 1);
    end
    for (int k = 0; k < 2; k++) begin
      mv(0); expect_(2, S_POS, pos_m); expect_(2, S_DIR, 0);
    end

    // R3 wrap at the ceiling and at zero
    pos_max = 5; max_m = 5;
    while (pos_m != 5) mv(1);
    expect_(3, S_POS, 5);
    mv(1); expect_(3, S_POS, 0);
    mv(0); expect_(3, S_POS, 5);
    mv(0); expect_(3, S_POS, 4);

    // R4 both phases change together
    clear(5'b11111);
    ph = (ph + 2) % 4; {enc_a, enc_b} = seq[ph];
    @(negedge clk);
    expect_(4, S_FBIT + 1, 1); expect_(4, S_POS, pos_m); expect_(4, S_DIR, dir_m);

    // R9 clearing one flag
    clear(5'b00010);
    expect_(9, S_FBIT + 1, 0);
    // R10 index capture
    mv(1);
    enc_i = 1'b1; @(negedge clk);
    expect_(10, S_IPOS, pos_m); expect_(10, S_FBIT + 4, 1);
    enc_i = 1'b0;
    ph = (ph + 2) % 4; {enc_a, enc_b} = seq[ph];
    @(negedge clk);
    expect_(4, S_FBIT + 1, 1);
    clear(5'b00010);
    // R9 other flag untouched
    expect_(9, S_FBIT + 1, 0); expect_(9, S_FBIT + 4, 1);
    // R11 interrupt follows the flags
    expect_(11, S_IRQ, 1);
    clear(5'b11111);
    expect_(11, S_IRQ, 0); expect_(9, S_FLG, 0);

    // R5 gap capture, two spacings
    mv(1); idle(9); mv(1);
    expect_(5, S_CAP, 10);
    mv(1);
    expect_(5, S_CAP, 1);

    // R6 saturation of the gap count
    idle(300);
    expect_(6, S_FBIT + 3, 1);
    mv(1);
    expect_(6, S_CAP, 255);

    // R7 stall watchdog
    wdog = 20;
    clr = 5'b11111; mv(1); clr = '0;
    idle(20);
    expect_(7, S_FBIT + 2, 0);
    idle(1);
    expect_(7, S_FBIT + 2, 1);

    // R8 unit timer interval and snapshot
    unit_p = 30;
    wait_unit(c);
    clear(5'b00001);
    wait_unit(c);
    check(8, 100, c + 1, 31);
    expect_(8, S_UPOS, pos_m);
    @(negedge clk);
    mv(1); mv(1);
    clear(5'b00001);
    wait_unit(c);
    expect_(8, S_UPOS, pos_m); expect_(8, S_FBIT + 0, 1);

    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule